// File: doc/BRIEF.md
# Dilated Sliding-Window Activation Fetcher

This block sequences the activation reads for a dilated one-dimensional convolution. For every input feature it walks the taps of the kernel. At each tap it reads one word of four adjacent samples, so a single read serves four neighbouring output windows at once. The tap reads are spaced by a dilation rate set at run time. The word each feature returns is copied to every sum-of-products unit in that feature's column. The local sample buffer sits outside the block and answers a read in the same cycle, so the block only produces addresses and routes the returned words.

A layer begins with a start pulse that captures the kernel size, the dilation, the channel base, the spacing between channels and the batch length. The fetcher then runs one pass per group of four outputs. After each pass the window base moves by four samples, and the passes repeat until the batch is covered. The batch is rounded up to a multiple of four. Alongside the configuration, the block reports the layer's receptive field and the number of samples the buffer must hold: the receptive field plus the batch of new samples. Every word it presents carries a first-tap flag and a last-tap flag, so the units know when to clear and when to finish their accumulators. A consumer that is not ready stalls the sequence without dropping or repeating a tap.

Top module: `dil_window_fetch`

## Requirements
- R1: After reset, busy, done and act_valid are low and the activation bus is all zeros.
- R2: Configuration inputs are sampled only on a start pulse while idle. A start pulse during a layer, and any change of the configuration inputs during a layer, have no effect on that layer's beats.
- R3: For beat tap k (0 to kernel_size-1) of pass p, feature f reads address (base + f*stride + 4*p + k*dilation) modulo 2^ADDR_W. A kernel size of 0 acts as 1.
- R4: A layer holds ceil(batch/4) passes of kernel_size beats each. The window base starts at 0 and rises by 4 after the last tap of each pass.
- R5: act_first is high exactly on tap 0 and act_last exactly on tap kernel_size-1. Both are high on a one-tap kernel.
- R6: While act_valid is high and act_ready is low, the addresses, the flags and the data all hold until the beat is accepted.
- R7: Feature f's word sits at rd_data_i[f*64 +: 64], with lane j (the sample at address+j) in bits [16j +: 16]. That word is copied to every unit u = f*ROWS + r at act_data_o[u*64 +: 64]. The bus reads zero while act_valid is low.
- R8: During a layer, rf_o equals 1 + (kernel_size-1)*dilation and span_o equals rf_o + batch.
- R9: done_o pulses for one cycle, in the cycle after the final beat is accepted, and busy then falls. A batch of 0 gives no beats and a done pulse in the cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a layer (taken only when idle) |
| cfg_ksize_i | input | KS_W | Kernel size in taps |
| cfg_dil_i | input | DIL_W | Dilation rate |
| cfg_base_i | input | ADDR_W | Address of feature 0's channel |
| cfg_stride_i | input | ADDR_W | Address distance between feature channels |
| cfg_batch_i | input | BATCH_W | New outputs to produce |
| rd_addr_o | output | NUM_IF*ADDR_W | Per-feature read address |
| rd_data_i | input | NUM_IF*64 | Per-feature four-sample word |
| act_ready_i | input | 1 | Consumer accepts the beat |
| act_valid_o | output | 1 | Beat present |
| act_first_o | output | 1 | Beat is tap 0 |
| act_last_o | output | 1 | Beat is the final tap |
| act_data_o | output | NUM_IF*ROWS*64 | Word broadcast to each unit |
| win_base_o | output | ADDR_W | Current window base |
| busy_o | output | 1 | Layer in progress |
| done_o | output | 1 | Layer finished pulse |
| rf_o | output | RF_W | Receptive field of the layer |
| span_o | output | SPAN_W | Samples per channel the buffer must hold |

## Verification
A tap counter or offset accumulator that drifts shows up on the very next beat as a wrong read address, and as a word that does not match the buffer model. A mistake in the pass count shows as a done pulse arriving early or late, measured against the expected beat total. A stall that advances state appears as a skipped or repeated tap in the first accepted beat after the stall. Broadcast wiring faults are caught on the first valid beat, because each feature holds distinct sample values.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
   localparam int unsigned DWF_SAMPLE_W = 16;
   localparam int unsigned DWF_LANES    = 4;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } dwf_state_t;
endpackage

// File: rtl/dwf_seq.sv
module dwf_seq
   import dwf_pkg::*;
#(
   parameter int unsigned KS_W    = 5,
   parameter int unsigned DIL_W   = 5,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned BATCH_W = 9,
   parameter int unsigned LANES   = 4,
   parameter int unsigned RF_W    = 11,
   parameter int unsigned SPAN_W  = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [KS_W-1:0]     cfg_ksize_i,
   input  logic [DIL_W-1:0]    cfg_dil_i,
   input  logic [ADDR_W-1:0]   cfg_base_i,
   input  logic [ADDR_W-1:0]   cfg_stride_i,
   input  logic [BATCH_W-1:0]  cfg_batch_i,
   input  logic                ready_i,
   output logic                busy_o,
   output logic                done_o,
   output logic                first_o,
   output logic                last_o,
   output logic [ADDR_W-1:0]   toff_o,
   output logic [ADDR_W-1:0]   wbase_o,
   output logic [ADDR_W-1:0]   base_o,
   output logic [ADDR_W-1:0]   stride_o,
   output logic [RF_W-1:0]     rf_o,
   output logic [SPAN_W-1:0]   span_o
);
   localparam int unsigned LG   = $clog2(LANES);
   localparam int unsigned PC_W = BATCH_W + 1;

   dwf_state_t          st_q;
   logic [KS_W-1:0]     ks_last_q, tap_q;
   logic [DIL_W-1:0]    dil_q;
   logic [ADDR_W-1:0]   base_q, stride_q, toff_q, wbase_q;
   logic [BATCH_W-1:0]  batch_q;
   logic [PC_W-1:0]     pass_q, npass_q;
   logic                done_q;

   logic [KS_W-1:0]     ks_eff_w;
   logic [PC_W-1:0]     passes_w;
   logic                fire_w, tap_end_w, pass_end_w;

   assign ks_eff_w   = (cfg_ksize_i == '0) ? KS_W'(1) : cfg_ksize_i;
   assign passes_w   = ({1'b0, cfg_batch_i} + PC_W'(LANES - 1)) >> LG;
   assign fire_w     = (st_q == ST_RUN) && ready_i;
   assign tap_end_w  = (tap_q == ks_last_q);
   assign pass_end_w = (pass_q == npass_q - PC_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         ks_last_q <= '0;
         tap_q     <= '0;
         dil_q     <= '0;
         base_q    <= '0;
         stride_q  <= '0;
         toff_q    <= '0;
         wbase_q   <= '0;
         batch_q   <= '0;
         pass_q    <= '0;
         npass_q   <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  ks_last_q <= ks_eff_w - KS_W'(1);
                  dil_q     <= cfg_dil_i;
                  base_q    <= cfg_base_i;
                  stride_q  <= cfg_stride_i;
                  batch_q   <= cfg_batch_i;
                  npass_q   <= passes_w;
                  tap_q     <= '0;
                  toff_q    <= '0;
                  wbase_q   <= '0;
                  pass_q    <= '0;
                  if (passes_w == '0) done_q <= 1'b1;
                  else                st_q   <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (fire_w) begin
                  if (tap_end_w) begin
                     tap_q  <= '0;
                     toff_q <= '0;
                     if (pass_end_w) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        pass_q  <= pass_q + PC_W'(1);
                        wbase_q <= wbase_q + ADDR_W'(LANES);
                     end
                  end else begin
                     tap_q  <= tap_q + KS_W'(1);
                     toff_q <= toff_q + ADDR_W'(dil_q);
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o   = (st_q == ST_RUN);
   assign done_o   = done_q;
   assign first_o  = busy_o && (tap_q == '0);
   assign last_o   = busy_o && tap_end_w;
   assign toff_o   = toff_q;
   assign wbase_o  = wbase_q;
   assign base_o   = base_q;
   assign stride_o = stride_q;
   assign rf_o     = RF_W'(1) + RF_W'(ks_last_q) * RF_W'(dil_q);
   assign span_o   = SPAN_W'(rf_o) + SPAN_W'(batch_q);
endmodule

// File: rtl/dwf_addr.sv
module dwf_addr #(
   parameter int unsigned NUM_IF = 12,
   parameter int unsigned ADDR_W = 12
) (
   input  logic [ADDR_W-1:0]        base_i,
   input  logic [ADDR_W-1:0]        stride_i,
   input  logic [ADDR_W-1:0]        wbase_i,
   input  logic [ADDR_W-1:0]        toff_i,
   output logic [NUM_IF*ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] common_w;
   assign common_w = base_i + wbase_i + toff_i;

   for (genvar f = 0; f < NUM_IF; f++) begin : g_feat
      if (f == 0) begin : g_zero
         assign addr_o[0 +: ADDR_W] = common_w;
      end else begin : g_off
         logic [ADDR_W-1:0] foff_w;
         assign foff_w = ADDR_W'(f) * stride_i;
         assign addr_o[f*ADDR_W +: ADDR_W] = common_w + foff_w;
      end
   end
endmodule

// File: rtl/dwf_bcast.sv
module dwf_bcast #(
   parameter int unsigned NUM_IF    = 12,
   parameter int unsigned ROWS      = 4,
   parameter int unsigned WORD_W    = 64,
   parameter bit          GATE_IDLE = 1'b1
) (
   input  logic                          valid_i,
   input  logic [NUM_IF*WORD_W-1:0]      word_i,
   output logic [NUM_IF*ROWS*WORD_W-1:0] unit_o
);
   logic [NUM_IF*WORD_W-1:0] src_w;

   if (GATE_IDLE) begin : g_gate
      assign src_w = valid_i ? word_i : '0;
   end else begin : g_pass
      assign src_w = word_i;
   end

   for (genvar f = 0; f < NUM_IF; f++) begin : g_col
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         assign unit_o[(f*ROWS + r)*WORD_W +: WORD_W] = src_w[f*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/dil_window_fetch.sv
module dil_window_fetch
   import dwf_pkg::*;
#(
   parameter int unsigned NUM_IF  = 12,
   parameter int unsigned ROWS    = 4,
   parameter int unsigned LANES   = DWF_LANES,
   parameter int unsigned SAMP_W  = DWF_SAMPLE_W,
   parameter int unsigned KS_W    = 5,
   parameter int unsigned DIL_W   = 5,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned BATCH_W = 9,
   parameter bit          GATE_IDLE = 1'b1,
   localparam int unsigned WORD_W = LANES * SAMP_W,
   localparam int unsigned RF_W   = KS_W + DIL_W + 1,
   localparam int unsigned SPAN_W = ((RF_W > BATCH_W) ? RF_W : BATCH_W) + 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic [KS_W-1:0]               cfg_ksize_i,
   input  logic [DIL_W-1:0]              cfg_dil_i,
   input  logic [ADDR_W-1:0]             cfg_base_i,
   input  logic [ADDR_W-1:0]             cfg_stride_i,
   input  logic [BATCH_W-1:0]            cfg_batch_i,
   output logic [NUM_IF*ADDR_W-1:0]      rd_addr_o,
   input  logic [NUM_IF*WORD_W-1:0]      rd_data_i,
   input  logic                          act_ready_i,
   output logic                          act_valid_o,
   output logic                          act_first_o,
   output logic                          act_last_o,
   output logic [NUM_IF*ROWS*WORD_W-1:0] act_data_o,
   output logic [ADDR_W-1:0]             win_base_o,
   output logic                          busy_o,
   output logic                          done_o,
   output logic [RF_W-1:0]               rf_o,
   output logic [SPAN_W-1:0]             span_o
);
   if (NUM_IF < 1 || ROWS < 1) begin : g_chk_dims
      $error("dil_window_fetch: NUM_IF and ROWS must be at least 1");
   end
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_chk_lanes
      $error("dil_window_fetch: LANES must be a power of two");
   end
   if (ADDR_W < $clog2(LANES) + 2 || KS_W < 1 || DIL_W < 1 || BATCH_W < 1) begin : g_chk_w
      $error("dil_window_fetch: widths too small");
   end

   logic [ADDR_W-1:0] toff_w, wbase_w, base_w, stride_w;

   dwf_seq #(
      .KS_W(KS_W), .DIL_W(DIL_W), .ADDR_W(ADDR_W), .BATCH_W(BATCH_W),
      .LANES(LANES), .RF_W(RF_W), .SPAN_W(SPAN_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cfg_ksize_i(cfg_ksize_i), .cfg_dil_i(cfg_dil_i),
      .cfg_base_i(cfg_base_i), .cfg_stride_i(cfg_stride_i),
      .cfg_batch_i(cfg_batch_i), .ready_i(act_ready_i),
      .busy_o(busy_o), .done_o(done_o),
      .first_o(act_first_o), .last_o(act_last_o),
      .toff_o(toff_w), .wbase_o(wbase_w), .base_o(base_w), .stride_o(stride_w),
      .rf_o(rf_o), .span_o(span_o)
   );

   dwf_addr #(.NUM_IF(NUM_IF), .ADDR_W(ADDR_W)) u_addr (
      .base_i(base_w), .stride_i(stride_w), .wbase_i(wbase_w),
      .toff_i(toff_w), .addr_o(rd_addr_o)
   );

   dwf_bcast #(
      .NUM_IF(NUM_IF), .ROWS(ROWS), .WORD_W(WORD_W), .GATE_IDLE(GATE_IDLE)
   ) u_bcast (
      .valid_i(busy_o), .word_i(rd_data_i), .unit_o(act_data_o)
   );

   assign act_valid_o = busy_o;
   assign win_base_o  = wbase_w;
endmodule

// File: rtl/dwf_checker.sv
module dwf_checker #(
   parameter int unsigned NUM_IF  = 12,
   parameter int unsigned ROWS    = 4,
   parameter int unsigned WORD_W  = 64,
   parameter int unsigned KS_W    = 5,
   parameter int unsigned DIL_W   = 5,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned RF_W    = 11
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          start_i,
   input logic [KS_W-1:0]               cfg_ksize_i,
   input logic [DIL_W-1:0]              cfg_dil_i,
   input logic [NUM_IF*ADDR_W-1:0]      rd_addr_o,
   input logic [NUM_IF*WORD_W-1:0]      rd_data_i,
   input logic                          act_ready_i,
   input logic                          act_valid_o,
   input logic                          act_first_o,
   input logic                          act_last_o,
   input logic [NUM_IF*ROWS*WORD_W-1:0] act_data_o,
   input logic                          busy_o,
   input logic                          done_o,
   input logic [RF_W-1:0]               rf_o
);
   logic [KS_W-1:0]  ks_q;
   logic [DIL_W-1:0] dil_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ks_q  <= KS_W'(1);
         dil_q <= '0;
      end else if (start_i && !busy_o) begin
         ks_q  <= (cfg_ksize_i == '0) ? KS_W'(1) : cfg_ksize_i;
         dil_q <= cfg_dil_i;
      end
   end

   // R6: a stalled beat keeps its address and flags
   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid_o && !act_ready_i |=> act_valid_o && $stable(rd_addr_o)
         && $stable(act_first_o) && $stable(act_last_o));

   // R5: the beat after an accepted last tap opens a new pass
   p_first_follows_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid_o && act_ready_i && act_last_o |=> !act_valid_o || act_first_o);

   // R3: consecutive taps of a pass are one dilation apart
   p_tap_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid_o && act_ready_i && !act_last_o |=>
         rd_addr_o[ADDR_W-1:0] == $past(rd_addr_o[ADDR_W-1:0]) + ADDR_W'(dil_q));

   // R9: done never overlaps an active layer
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && !act_valid_o);

   // R8: receptive field follows the captured kernel and dilation
   p_rf_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> rf_o == RF_W'(1) + RF_W'(ks_q - KS_W'(1)) * RF_W'(dil_q));

   // R2: a start during a layer leaves the receptive field untouched
   p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i |=> $stable(rf_o));

   for (genvar f = 0; f < NUM_IF; f++) begin : g_f
      for (genvar r = 0; r < ROWS; r++) begin : g_r
         // R7: every unit of a column carries its feature's word
         p_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
            act_valid_o |-> act_data_o[(f*ROWS + r)*WORD_W +: WORD_W]
                            == rd_data_i[f*WORD_W +: WORD_W]);
      end
   end
endmodule

bind dil_window_fetch dwf_checker #(
   .NUM_IF(NUM_IF), .ROWS(ROWS), .WORD_W(WORD_W), .KS_W(KS_W),
   .DIL_W(DIL_W), .ADDR_W(ADDR_W), .RF_W(RF_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i),
   .cfg_ksize_i(cfg_ksize_i), .cfg_dil_i(cfg_dil_i),
   .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
   .act_ready_i(act_ready_i), .act_valid_o(act_valid_o),
   .act_first_o(act_first_o), .act_last_o(act_last_o),
   .act_data_o(act_data_o), .busy_o(busy_o), .done_o(done_o), .rf_o(rf_o)
);

// File: tb/dil_window_fetch_bench.sv
module dil_window_fetch_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_IF  = 12;
   localparam int ROWS    = 4;
   localparam int KS_W    = 5;
   localparam int DIL_W   = 5;
   localparam int ADDR_W  = 12;
   localparam int BATCH_W = 9;
   localparam int WORD_W  = 64;
   localparam int RF_W    = KS_W + DIL_W + 1;
   localparam int SPAN_W  = RF_W + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [KS_W-1:0]    cfg_ksize_i = '0;
   logic [DIL_W-1:0]   cfg_dil_i = '0;
   logic [ADDR_W-1:0]  cfg_base_i = '0;
   logic [ADDR_W-1:0]  cfg_stride_i = '0;
   logic [BATCH_W-1:0] cfg_batch_i = '0;
   logic act_ready_i = 1'b0;
   logic [NUM_IF*ADDR_W-1:0]      rd_addr_o;
   logic [NUM_IF*WORD_W-1:0]      rd_data_i;
   logic act_valid_o, act_first_o, act_last_o, busy_o, done_o;
   logic [NUM_IF*ROWS*WORD_W-1:0] act_data_o;
   logic [ADDR_W-1:0]             win_base_o;
   logic [RF_W-1:0]               rf_o;
   logic [SPAN_W-1:0]             span_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dil_window_fetch u_dil_window_fetch (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cfg_ksize_i(cfg_ksize_i), .cfg_dil_i(cfg_dil_i),
      .cfg_base_i(cfg_base_i), .cfg_stride_i(cfg_stride_i),
      .cfg_batch_i(cfg_batch_i), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
      .act_ready_i(act_ready_i), .act_valid_o(act_valid_o),
      .act_first_o(act_first_o), .act_last_o(act_last_o),
      .act_data_o(act_data_o), .win_base_o(win_base_o),
      .busy_o(busy_o), .done_o(done_o), .rf_o(rf_o), .span_o(span_o)
   );

   // buffer model: each feature holds distinct sample values
   function automatic logic [WORD_W-1:0] mem_word(int f, logic [ADDR_W-1:0] a);
      logic [WORD_W-1:0] w;
      for (int j = 0; j < 4; j++) w[j*16 +: 16] = 16'(f * 4099 + int'(a) + j);
      return w;
   endfunction

   always_comb begin
      for (int f = 0; f < NUM_IF; f++)
         rd_data_i[f*WORD_W +: WORD_W] = mem_word(f, rd_addr_o[f*ADDR_W +: ADDR_W]);
   end

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one beat: addresses (R3, or R6 when re-checked after a stall), flags (R5), data (R7)
   task automatic check_beat(int k, int p, int ks_e, int dil, int base, int stride, bit stalled);
      bit aok = 1'b1, dok = 1'b1;
      longint aa = 0, ae = 0, da = 0, de = 0;
      string rq = stalled ? "R6" : "R3";
      for (int f = 0; f < NUM_IF; f++) begin
         logic [ADDR_W-1:0] ea = ADDR_W'(base + f*stride + 4*p + k*dil);
         if (rd_addr_o[f*ADDR_W +: ADDR_W] !== ea && aok) begin
            aok = 1'b0; aa = longint'(rd_addr_o[f*ADDR_W +: ADDR_W]); ae = longint'(ea);
         end
         for (int r = 0; r < ROWS; r++)
            if (act_data_o[(f*ROWS+r)*WORD_W +: WORD_W] !== mem_word(f, ea) && dok) begin
               dok = 1'b0;
               da = longint'(act_data_o[(f*ROWS+r)*WORD_W +: WORD_W]);
               de = longint'(mem_word(f, ea));
            end
      end
      check(act_valid_o === 1'b1, rq, "valid", longint'(act_valid_o), 1);
      check(aok, rq, "tap address", aa, ae);
      check(win_base_o === ADDR_W'(4*p), "R4", "window base", longint'(win_base_o), 4*p);
      check(act_first_o === (k == 0) && act_last_o === (k == ks_e-1), "R5", "first/last",
            longint'({act_first_o, act_last_o}), longint'({k == 0, k == ks_e-1}));
      check(dok, "R7", "broadcast word", da, de);
   endtask

   task automatic run_layer(int ks, int dil, int base, int stride, int batch, bit inj, int rmode);
      int ks_e = (ks == 0) ? 1 : ks;
      int total = ((batch + 3) / 4) * ks_e;
      int beat = 0, guard = 0;
      bit stalled = 1'b0;
      @(negedge clk);
      cfg_ksize_i = KS_W'(ks); cfg_dil_i = DIL_W'(dil); cfg_base_i = ADDR_W'(base);
      cfg_stride_i = ADDR_W'(stride); cfg_batch_i = BATCH_W'(batch);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cfg_ksize_i = KS_W'($urandom); cfg_dil_i = DIL_W'($urandom);
      cfg_base_i = ADDR_W'($urandom); cfg_stride_i = ADDR_W'($urandom);
      cfg_batch_i = BATCH_W'($urandom);
      if (total == 0) begin
         check(done_o === 1'b1 && busy_o === 1'b0, "R9", "empty batch done",
               longint'({done_o, busy_o}), 2);
      end else begin
         check(rf_o === RF_W'(1 + (ks_e-1)*dil), "R8", "receptive field",
               longint'(rf_o), 1 + (ks_e-1)*dil);
         check(span_o === SPAN_W'(1 + (ks_e-1)*dil + batch), "R8", "buffer span",
               longint'(span_o), 1 + (ks_e-1)*dil + batch);
         while (beat < total && guard < 4000) begin
            check_beat(beat % ks_e, beat / ks_e, ks_e, dil, base, stride, stalled);
            act_ready_i = (rmode == 0) ? 1'b1 : (($urandom % 3) != 0);
            if (inj && beat == 1) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            stalled = !act_ready_i;
            if (act_ready_i) beat++;
            guard++;
         end
         check(beat == total, "R4", "beat count", beat, total);
         check(done_o === 1'b1 && busy_o === 1'b0, "R9", "done after last beat",
               longint'({done_o, busy_o}), 2);
      end
      act_ready_i = 1'b0;
      @(negedge clk);
      check(done_o === 1'b0, "R9", "done single cycle", longint'(done_o), 0);
      check(act_valid_o === 1'b0 && act_data_o === '0, "R7", "idle bus zero",
            longint'(act_valid_o), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      check(busy_o === 1'b0 && done_o === 1'b0 && act_valid_o === 1'b0, "R1",
            "reset state", longint'({busy_o, done_o, act_valid_o}), 0);
      check(act_data_o === '0, "R1", "reset bus", 0, 0);
      rst_n = 1'b1;
      // directed corners
      run_layer(1, 0, 0, 16, 1, 1'b0, 0);      // single tap, one pass
      run_layer(0, 3, 100, 40, 5, 1'b0, 1);    // zero kernel acts as one tap
      run_layer(3, 2, 50, 64, 0, 1'b0, 0);     // empty batch
      run_layer(8, 8, 10, 200, 8, 1'b1, 1);    // start injected mid-layer (R2)
      run_layer(4, 31, 4090, 300, 7, 1'b0, 1); // address wrap
      run_layer(31, 1, 7, 33, 4, 1'b0, 0);     // longest kernel
      for (int i = 0; i < 30; i++)
         run_layer(int'($urandom % 10), int'($urandom % 13), int'($urandom % 4096),
                   int'($urandom % 4096), int'($urandom % 14), ($urandom % 4) == 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule